// File: doc/BRIEF.md
# Indexed Pixel Colour Path with Cursor Overlay

This block turns a stream of 8-bit indexed pixels into 24-bit RGB for a raster display. Each accepted pixel arrives with its screen coordinates. It is translated through a 256-entry colour table. Inside a 64x64 cursor square, a two-bit-per-pixel cursor image is laid over the picture. Code zero in that image lets the picture show through. The other three codes pick one of three cursor colours. Two per-pixel controls are sampled with each pixel: one blacks out the output, and one removes the cursor.

The colour table, the cursor image and the cursor colours are loaded through plain synchronous write ports. Fetching the frame, producing video timing and decoding register addresses happen elsewhere. The output trails the input by a fixed two-cycle delay, and the valid and end-of-line flags travel along with the data.

Top module: `cursor_palette_pipe`

## Requirements
- R1: After reset, `out_valid`, `out_eol` and `out_rgb` are zero, and all three cursor colours are zero until they are written.
- R2: A pixel sampled with `in_valid` high at clock edge n is presented with `out_valid` high after edge n+1. `out_eol` follows `in_eol` for valid pixels with the same delay and is never high without `out_valid`. `out_rgb` is zero whenever `out_valid` is low.
- R3: Outside the cursor area, `out_rgb` is the colour table entry addressed by `in_index`, with red in bits 23:16, green in 15:8 and blue in 7:0.
- R4: The cursor x origin is `cur_pos[31:12]` and the y origin is `cur_pos[11:0]`. A pixel lies in the cursor area when cx <= x < cx+64 and cy <= y < cy+64. An origin of 4096 or more therefore gives no hits.
- R5: For a pixel in the area, the cursor image word is number (y-cy)*8 + (x-cx)/8. Its code is the two bits starting at bit 2*((x-cx) mod 8), so bits 1:0 belong to the leftmost pixel.
- R6: Code 0 gives the colour table entry of the pixel. Codes 1, 2 and 3 give cursor colours 0, 1 and 2.
- R7: When `ctl_nocursor` is high with a pixel, that pixel takes its colour table value even inside the cursor area.
- R8: When `ctl_blank` is high with a pixel, that pixel comes out as 0x000000. This overrides every other rule.
- R9: A colour table or cursor image write takes effect for pixels presented from the next cycle on. A pixel presented in the same cycle as the write sees the old entry.
- R10: A cursor colour write to `cpal_waddr` 0, 1 or 2 applies to pixels presented in the same cycle and in later cycles. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel valid |
| in_index | input | 8 | Colour table index of the pixel |
| in_x | input | 12 | Pixel column |
| in_y | input | 12 | Pixel row |
| in_eol | input | 1 | Last pixel of the line |
| cur_pos | input | 32 | Cursor origin: x in 31:12, y in 11:0 |
| ctl_blank | input | 1 | Force black output |
| ctl_nocursor | input | 1 | Suppress the cursor overlay |
| pal_we | input | 1 | Colour table write enable |
| pal_waddr | input | 8 | Colour table write address |
| pal_wdata | input | 24 | Colour table write data (R,G,B) |
| cpal_we | input | 1 | Cursor colour write enable |
| cpal_waddr | input | 2 | Cursor colour address (0..2) |
| cpal_wdata | input | 24 | Cursor colour write data (R,G,B) |
| pat_we | input | 1 | Cursor image write enable |
| pat_waddr | input | 9 | Cursor image word address |
| pat_wdata | input | 16 | Cursor image word |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Output colour |
| out_eol | output | 1 | Last pixel of the line, delayed |

## Verification
The hardest cases to reach are the ones where a table write lands in the same cycle as a pixel that reads the same entry. The colour table and cursor image keep the old value in that case, while the cursor colours take the new one. Directed steps set up these collisions on purpose. Random phases also mix writes into a dense pixel stream whose coordinates cluster around the cursor. That makes window edges and all four codes common, and blanking and cursor suppression are toggled now and then. Other directed steps place pixels one inside and one outside each edge of the window, and put the origin beyond the 12-bit coordinate range.

// File: rtl/cpp_pkg.sv
package cpp_pkg;
    localparam int CHAN_W       = 8;
    localparam int RGB_W        = 3 * CHAN_W;
    localparam int IDX_W        = 8;
    localparam int PAL_AW       = IDX_W;
    localparam int COORD_W      = 12;
    localparam int POS_W        = 32;
    localparam int CX_W         = POS_W - COORD_W;
    localparam int CUR_DIM      = 64;
    localparam int CUR_LOG      = $clog2(CUR_DIM);
    localparam int PAT_W        = 16;
    localparam int PIX_PER_WORD = PAT_W / 2;
    localparam int PPW_LOG      = $clog2(PIX_PER_WORD);
    localparam int PAT_AW       = 2 * CUR_LOG - PPW_LOG;
    localparam int CPAL_N       = 3;
    localparam int CPAL_AW      = 2;

    typedef struct packed {
        logic               vld;
        logic               eol;
        logic               blank;
        logic               hit;
        logic [PPW_LOG-1:0] sel;
    } stage1_t;

    typedef struct packed {
        logic             vld;
        logic             eol;
        logic [RGB_W-1:0] rgb;
    } stage2_t;
endpackage

// File: rtl/cpp_ram.sv
module cpp_ram #(
    parameter int W  = 24,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/cpp_hit.sv
module cpp_hit
    import cpp_pkg::*;
(
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  logic [POS_W-1:0]   pos,
    output logic               hit,
    output logic [PAT_AW-1:0]  word_addr,
    output logic [PPW_LOG-1:0] sel
);
    localparam int XE_W = CX_W + 1;
    localparam int YE_W = COORD_W + 1;

    logic [XE_W-1:0] xe, cxe, dx;
    logic [YE_W-1:0] ye, cye, dy;
    logic            in_x, in_y;

    always_comb begin
        xe   = XE_W'(x);
        cxe  = {1'b0, pos[POS_W-1:COORD_W]};
        dx   = xe - cxe;
        ye   = {1'b0, y};
        cye  = {1'b0, pos[COORD_W-1:0]};
        dy   = ye - cye;
        in_x = (xe >= cxe) && (dx < XE_W'(CUR_DIM));
        in_y = (ye >= cye) && (dy < YE_W'(CUR_DIM));
        hit  = in_x && in_y;
        word_addr = {dy[CUR_LOG-1:0], dx[CUR_LOG-1:PPW_LOG]};
        sel       = dx[PPW_LOG-1:0];
    end
endmodule

// File: rtl/cpp_mix.sv
module cpp_mix
    import cpp_pkg::*;
(
    input  stage1_t                       s1,
    input  logic [RGB_W-1:0]              pal_rd,
    input  logic [PAT_W-1:0]              pat_rd,
    input  logic [CPAL_N-1:0][RGB_W-1:0]  cpal,
    output stage2_t                       s2
);
    logic [1:0]       code;
    logic [RGB_W-1:0] cur_col;

    always_comb begin
        code = '0;
        for (int i = 0; i < PIX_PER_WORD; i++) begin
            if (s1.sel == PPW_LOG'(i)) begin
                code = pat_rd[2*i +: 2];
            end
        end
        cur_col = pal_rd;
        for (int j = 0; j < CPAL_N; j++) begin
            if (code == 2'(j + 1)) begin
                cur_col = cpal[j];
            end
        end
        s2.vld = s1.vld;
        s2.eol = s1.vld && s1.eol;
        if (!s1.vld || s1.blank) begin
            s2.rgb = '0;
        end else if (s1.hit) begin
            s2.rgb = cur_col;
        end else begin
            s2.rgb = pal_rd;
        end
    end
endmodule

// File: rtl/cursor_palette_pipe.sv
module cursor_palette_pipe
    import cpp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [IDX_W-1:0]    in_index,
    input  logic [COORD_W-1:0]  in_x,
    input  logic [COORD_W-1:0]  in_y,
    input  logic                in_eol,
    input  logic [POS_W-1:0]    cur_pos,
    input  logic                ctl_blank,
    input  logic                ctl_nocursor,
    input  logic                pal_we,
    input  logic [PAL_AW-1:0]   pal_waddr,
    input  logic [RGB_W-1:0]    pal_wdata,
    input  logic                cpal_we,
    input  logic [CPAL_AW-1:0]  cpal_waddr,
    input  logic [RGB_W-1:0]    cpal_wdata,
    input  logic                pat_we,
    input  logic [PAT_AW-1:0]   pat_waddr,
    input  logic [PAT_W-1:0]    pat_wdata,
    output logic                out_valid,
    output logic [RGB_W-1:0]    out_rgb,
    output logic                out_eol
);
    typedef struct packed {
        stage1_t                      s1;
        stage2_t                      s2;
        logic [CPAL_N-1:0][RGB_W-1:0] cpal;
    } state_t;

    state_t st_d, st_q;

    logic               hit_w;
    logic [PAT_AW-1:0]  pat_raddr_w;
    logic [PPW_LOG-1:0] sel_w;
    logic [RGB_W-1:0]   pal_rd;
    logic [PAT_W-1:0]   pat_rd;
    stage2_t            s2_w;

    cpp_hit u_hit (
        .x         (in_x),
        .y         (in_y),
        .pos       (cur_pos),
        .hit       (hit_w),
        .word_addr (pat_raddr_w),
        .sel       (sel_w)
    );

    cpp_ram #(.W(RGB_W), .AW(PAL_AW)) u_pal (
        .clk   (clk),
        .we    (pal_we),
        .waddr (pal_waddr),
        .wdata (pal_wdata),
        .raddr (in_index),
        .rdata (pal_rd)
    );

    cpp_ram #(.W(PAT_W), .AW(PAT_AW)) u_pat (
        .clk   (clk),
        .we    (pat_we),
        .waddr (pat_waddr),
        .wdata (pat_wdata),
        .raddr (pat_raddr_w),
        .rdata (pat_rd)
    );

    cpp_mix u_mix (
        .s1     (st_q.s1),
        .pal_rd (pal_rd),
        .pat_rd (pat_rd),
        .cpal   (st_q.cpal),
        .s2     (s2_w)
    );

    always_comb begin
        st_d          = st_q;
        st_d.s1.vld   = in_valid;
        st_d.s1.eol   = in_valid && in_eol;
        st_d.s1.blank = ctl_blank;
        st_d.s1.hit   = hit_w && !ctl_nocursor;
        st_d.s1.sel   = sel_w;
        st_d.s2       = s2_w;
        if (cpal_we && (int'(cpal_waddr) < CPAL_N)) begin
            st_d.cpal[cpal_waddr] = cpal_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.s2.vld;
    assign out_rgb   = st_q.s2.rgb;
    assign out_eol   = st_q.s2.eol;
endmodule

// File: rtl/cpp_chk.sv
module cpp_chk
    import cpp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_eol,
    input logic             ctl_blank,
    input logic             out_valid,
    input logic [RGB_W-1:0] out_rgb,
    input logic             out_eol
);
    logic [1:0] age_q;
    logic       ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end

    assign ready = (age_q == 2'd2);

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (out_valid == $past(in_valid, 2))); // R2
    AST_EOL_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (out_eol == $past(in_valid && in_eol, 2))); // R2
    AST_EOL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_eol |-> out_valid); // R2
    AST_IDLE_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_rgb == '0)); // R2
    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(in_valid && ctl_blank, 2)) |-> (out_rgb == '0)); // R8
endmodule

bind cursor_palette_pipe cpp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_eol    (in_eol),
    .ctl_blank (ctl_blank),
    .out_valid (out_valid),
    .out_rgb   (out_rgb),
    .out_eol   (out_eol)
);

// File: tb/tb_cursor_palette_pipe.sv
`timescale 1ns/1ps
module tb_cursor_palette_pipe;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_eol, ctl_blank, ctl_nocursor;
    logic [7:0]  in_index;
    logic [11:0] in_x, in_y;
    logic [31:0] cur_pos;
    logic        pal_we, cpal_we, pat_we;
    logic [7:0]  pal_waddr;
    logic [23:0] pal_wdata, cpal_wdata;
    logic [1:0]  cpal_waddr;
    logic [8:0]  pat_waddr;
    logic [15:0] pat_wdata;
    logic        out_valid, out_eol;
    logic [23:0] out_rgb;

    always #2.5 clk = ~clk;

    cursor_palette_pipe dut (.*);

    logic [23:0] m_pal [256];
    logic [15:0] m_pat [512];
    logic [23:0] m_cpal [3];

    logic        e_v, e_e;
    logic [23:0] e_rgb;
    string       e_tag;
    string       ftag;
    int          total = 0;
    int          bad   = 0;
    bit          done  = 0;

    function automatic void predict(output logic [23:0] rgb, output string tag);
        int cx, cy, dx, dy, code;
        bit hit;
        cx = int'(cur_pos[31:12]);
        cy = int'(cur_pos[11:0]);
        dx = int'(in_x) - cx;
        dy = int'(in_y) - cy;
        hit = !ctl_nocursor && dx >= 0 && dx < 64 && dy >= 0 && dy < 64;
        code = 0;
        if (hit) code = int'((m_pat[dy*8 + dx/8] >> (2*(dx % 8))) & 16'h3);
        if (ctl_blank) begin
            rgb = '0; tag = "R8";
        end else if (hit && code != 0) begin
            rgb = m_cpal[code-1]; tag = "R6";
        end else begin
            rgb = m_pal[in_index];
            tag = ctl_nocursor ? "R7" : (hit ? "R5" : "R3");
        end
    endfunction

    task automatic check_out();
        total++;
        if (out_valid !== e_v || out_eol !== e_e || out_rgb !== e_rgb) begin
            bad++;
            $display("FAIL %s: got v=%b eol=%b rgb=%06h, expected v=%b eol=%b rgb=%06h",
                     e_tag, out_valid, out_eol, out_rgb, e_v, e_e, e_rgb);
        end
    endtask

    task automatic idle_inputs();
        in_valid = 0; in_eol = 0; pal_we = 0; cpal_we = 0; pat_we = 0;
    endtask

    // inputs are set by the caller after a falling edge; step predicts, updates models, advances
    task automatic step();
        logic        nv, ne;
        logic [23:0] nrgb;
        string       ntag;
        if (cpal_we && cpal_waddr != 2'd3) m_cpal[cpal_waddr] = cpal_wdata;
        nv = in_valid;
        ne = in_valid && in_eol;
        if (in_valid) predict(nrgb, ntag);
        else begin nrgb = '0; ntag = "R2"; end
        if (ftag != "") ntag = ftag;
        if (pal_we) m_pal[pal_waddr] = pal_wdata;
        if (pat_we) m_pat[pat_waddr] = pat_wdata;
        @(negedge clk);
        check_out();
        e_v = nv; e_e = ne; e_rgb = nrgb; e_tag = ntag;
        idle_inputs();
    endtask

    task automatic pix(input [7:0] idx, input [11:0] x, input [11:0] y, input [31:0] pos,
                       input bl, input nc);
        in_valid = 1; in_index = idx; in_x = x; in_y = y; cur_pos = pos;
        ctl_blank = bl; ctl_nocursor = nc; in_eol = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        ftag = "";
        rst_n = 0;
        idle_inputs();
        in_index = 0; in_x = 0; in_y = 0; cur_pos = 0; ctl_blank = 0; ctl_nocursor = 0;
        pal_waddr = 0; pal_wdata = 0; cpal_waddr = 0; cpal_wdata = 0; pat_waddr = 0; pat_wdata = 0;
        for (int i = 0; i < 256; i++) m_pal[i] = '0;
        for (int i = 0; i < 512; i++) m_pat[i] = '0;
        for (int i = 0; i < 3; i++) m_cpal[i] = '0;
        e_v = 0; e_e = 0; e_rgb = 0; e_tag = "R1";
        // R1: outputs quiet in reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_out();
        end
        rst_n = 1;

        // R1: cursor colours zero after reset
        pal_we = 1; pal_waddr = 8'h40; pal_wdata = 24'hABCDEF; step();
        pat_we = 1; pat_waddr = 0; pat_wdata = 16'h0001; step();
        ftag = "R1";
        pix(8'h40, 0, 0, 0, 0, 0); step();
        pix(8'h40, 1, 0, 0, 0, 0); step();
        ftag = "";

        // load tables
        for (int i = 0; i < 256; i++) begin
            pal_we = 1; pal_waddr = 8'(i); pal_wdata = 24'($urandom); step();
        end
        for (int i = 0; i < 512; i++) begin
            pat_we = 1; pat_waddr = 9'(i); pat_wdata = 16'($urandom); step();
        end

        // R10: cursor colours, address 3 ignored, same-cycle visibility
        for (int i = 0; i < 3; i++) begin
            cpal_we = 1; cpal_waddr = 2'(i); cpal_wdata = 24'h111111 * (i + 1); step();
        end
        pat_we = 1; pat_waddr = 0; pat_wdata = 16'h00E4; step();
        cpal_we = 1; cpal_waddr = 2'd3; cpal_wdata = 24'hFFFFFF; step();
        ftag = "R10";
        for (int i = 0; i < 4; i++) begin
            pix(8'h12, 12'(i), 0, 0, 0, 0); step();
        end
        pix(8'h12, 2, 0, 0, 0, 0);
        cpal_we = 1; cpal_waddr = 2'd1; cpal_wdata = 24'h5A5A5A; step();

        // R5: code placement within words
        ftag = "R5";
        pat_we = 1; pat_waddr = 9'(5*8 + 2); pat_wdata = 16'hC000; step();
        for (int i = 16; i < 24; i++) begin
            pix(8'h33, 12'(300 + i), 12'(400 + 5), {20'd300, 12'd400}, 0, 0); step();
        end

        // R4: window edges
        ftag = "R4";
        for (int i = 0; i < 64; i += 8) begin
            pat_we = 1; pat_waddr = 9'(i); pat_wdata = 16'hFFFF; step();
            pat_we = 1; pat_waddr = 9'(i + 7 + 63*8 - 63*8); pat_wdata = 16'hFFFF; step();
        end
        for (int i = 0; i < 8; i++) begin
            pat_we = 1; pat_waddr = 9'(63*8 + i); pat_wdata = 16'hFFFF; step();
        end
        pix(1, 99, 200, {20'd100, 12'd200}, 0, 0); step();
        pix(1, 100, 200, {20'd100, 12'd200}, 0, 0); step();
        pix(1, 163, 200, {20'd100, 12'd200}, 0, 0); step();
        pix(1, 164, 200, {20'd100, 12'd200}, 0, 0); step();
        pix(1, 100, 199, {20'd100, 12'd200}, 0, 0); step();
        pix(1, 100, 263, {20'd100, 12'd200}, 0, 0); step();
        pix(1, 100, 264, {20'd100, 12'd200}, 0, 0); step();
        pix(1, 12'd4095, 0, {20'd4096, 12'd0}, 0, 0); step();
        pix(1, 0, 0, {20'h80000, 12'd0}, 0, 0); step();

        // R7, R8 inside the window
        ftag = "R7";
        pix(9, 100, 200, {20'd100, 12'd200}, 0, 1); step();
        ftag = "R8";
        pix(9, 100, 200, {20'd100, 12'd200}, 1, 0); step();
        pix(9, 5, 5, {20'd100, 12'd200}, 1, 1); step();

        // R9: same-cycle write collisions
        ftag = "R9";
        pix(7, 900, 900, 0, 0, 0); pal_we = 1; pal_waddr = 7; pal_wdata = 24'h0F0F0F; step();
        pix(7, 900, 900, 0, 0, 0); step();
        pix(7, 100, 200, {20'd100, 12'd200}, 0, 0); pat_we = 1; pat_waddr = 0; pat_wdata = 16'h0000; step();
        pix(7, 100, 200, {20'd100, 12'd200}, 0, 0); step();

        // R2: gaps and end-of-line flags
        ftag = "R2";
        for (int i = 0; i < 6; i++) begin
            if (i % 2 == 0) begin pix(8'(i), 12'(i), 3, 0, 0, 0); in_eol = (i == 4); end
            step();
        end
        ftag = "";

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int cx, cy;
            cx = 200 + int'($urandom % 64);
            cy = 300 + int'($urandom % 64);
            if ($urandom % 5 != 0) begin
                pix(8'($urandom), 12'(cx - 16 + int'($urandom % 96)), 12'(cy - 16 + int'($urandom % 96)),
                    {20'(cx), 12'(cy)}, ($urandom % 16) == 0, ($urandom % 8) == 0);
                in_eol = ($urandom % 10) == 0;
            end
            if ($urandom % 8 == 0) begin pal_we = 1; pal_waddr = 8'($urandom); pal_wdata = 24'($urandom); end
            if ($urandom % 8 == 0) begin pat_we = 1; pat_waddr = 9'($urandom); pat_wdata = 16'($urandom); end
            if ($urandom % 16 == 0) begin cpal_we = 1; cpal_waddr = 2'($urandom); cpal_wdata = 24'($urandom); end
            step();
        end
        for (int i = 0; i < 3; i++) step();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule